// File: doc/BRIEF.md
# Reordering DRAM Command Arbiter with Starvation Guard

This block holds a small pool of pending DRAM read and write requests and, each cycle, offers one of them as the next command to issue. Every request carries a rank, a bank, a row, a direction bit and an urgency bit. To save bus turnaround and row switching, the arbiter favours requests whose row is already open in their bank. In grouping mode it also favours requests that continue the current direction. Urgent requests may overtake normal ones. Every held request counts how many commands were granted ahead of it. Once that count reaches a programmable limit, the request is forced out next.

Requests enter on a valid/ready stream. `in_ready` depends only on the pool occupancy and never on `out_ready`. A request is taken on a cycle where `in_valid` and `in_ready` are both high. Commands leave on a second valid/ready stream. A command is granted on a cycle where `out_valid` and `out_ready` are both high. Once raised, `out_valid` stays high until a grant. While the sink holds `out_ready` low, the offered command may change if a better candidate becomes eligible. The open-row table is updated by each grant, so the block keeps a model of which row each rank/bank holds open.

Top module: `cmd_arb`

## Requirements
- R1: `in_ready` is high exactly when fewer than DEPTH (default 8) requests are held. A request is stored when `in_valid` and `in_ready` are both high, even in a cycle where a grant also happens. The new request becomes eligible for grant in the following cycle.
- R2: `out_valid` is high exactly when at least one request is held. Each grant (`out_valid` and `out_ready` high) removes exactly the offered request. `out_rank`, `out_bank`, `out_row`, `out_wr` and `out_hipri` show the fields of the offered request.
- R3: A new request starts with a wait count of 0. Each grant adds one to the wait count of every other held request, saturating at 63.
- R4: A request whose wait count is at least `starve_limit` (meaningful range 1 to 63) is starved. When any request is starved, the offered command is a starved one. A `starve_limit` of 0 makes every held request starved.
- R5: With no starved request, the order is an urgent (`hipri`=1) row hit first, then any urgent request.
- R6: Each rank/bank pair has an open-row entry. All entries are closed after reset. A grant marks the granted row as open for its rank/bank. A held request is a row hit when its rank/bank entry is open and holds the same row. `out_hit` shows whether the offered command is a row hit.
- R7: When `major_mode` is 1, a row hit whose direction matches the last granted command (`wr`: 0 = read, 1 = write; read after reset) comes next after the urgent tiers. When `major_mode` is 0, this tier is skipped.
- R8: After the tiers above, any row hit comes next, and then any request. Within the winning tier, the request with the largest wait count wins. Ties go to the lowest storage slot. Slots are filled lowest free first.
- R9: During and right after reset, the pool is empty: `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Pool has a free slot |
| in_rank | input | RANK_W | Request rank |
| in_bank | input | BANK_W | Request bank |
| in_row | input | ROW_W | Request row |
| in_wr | input | 1 | Direction, 1 = write |
| in_hipri | input | 1 | Urgent request |
| starve_limit | input | 6 | Wait count that forces a request out |
| major_mode | input | 1 | Enable same-direction grouping tier |
| out_valid | output | 1 | Command offered |
| out_ready | input | 1 | Sink takes the command |
| out_rank | output | RANK_W | Command rank |
| out_bank | output | BANK_W | Command bank |
| out_row | output | ROW_W | Command row |
| out_wr | output | 1 | Command direction |
| out_hipri | output | 1 | Command was urgent |
| out_hit | output | 1 | Command hits the open row |

## Verification
The bench sweeps every starvation limit class: 0, 1, a small value, a mid value and 63. Each limit is run with grouping on and off, under traffic with few distinct rows, so that hits, direction runs, saturation and forced-out requests all happen. Several mistakes would show up as a different offered command or a wrong `out_hit` flag. Aging the granted or newly accepted entry, failing to saturate at 63, or comparing the limit with > instead of >= would each offer the wrong command. So would letting the grouping tier run with grouping off, or letting the open-row table miss an update. The bench also accepts and grants in the same cycle with a full pool, which catches a ready signal that reuses the slot being freed.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
  localparam int AGE_W   = 6;
  localparam int AGE_MAX = (1 << AGE_W) - 1;
  localparam int NTIER   = 6;
  localparam int T_STARVED = 0;
  localparam int T_HP_HIT  = 1;
  localparam int T_HP      = 2;
  localparam int T_DIR_HIT = 3;
  localparam int T_HIT     = 4;
  localparam int T_ANY     = 5;
endpackage

// File: rtl/cmd_arb_open_rows.sv
module cmd_arb_open_rows #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  localparam int KEY_W = RANK_W + BANK_W,
  localparam int NSLOT = 1 << KEY_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd,
  input  logic [RANK_W-1:0]             upd_rank,
  input  logic [BANK_W-1:0]             upd_bank,
  input  logic [ROW_W-1:0]              upd_row,
  input  logic [DEPTH-1:0][RANK_W-1:0]  ent_rank,
  input  logic [DEPTH-1:0][BANK_W-1:0]  ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   ent_row,
  output logic [DEPTH-1:0]              ent_hit
);
  logic [NSLOT-1:0]            open_v;
  logic [NSLOT-1:0][ROW_W-1:0] open_row;
  logic [KEY_W-1:0]            upd_key;

  assign upd_key = {upd_rank, upd_bank};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v   <= '0;
      open_row <= '0;
    end else if (upd) begin
      open_v[upd_key]   <= 1'b1;
      open_row[upd_key] <= upd_row;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    logic [KEY_W-1:0] key;
    assign key        = {ent_rank[i], ent_bank[i]};
    assign ent_hit[i] = open_v[key] && (open_row[key] == ent_row[i]);
  end

  // R6: a bank just updated holds the new row on the next cycle
  a_r6_row_opened: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> open_v[$past(upd_key)] && (open_row[$past(upd_key)] == $past(upd_row)));
endmodule

// File: rtl/cmd_arb_picker.sv
module cmd_arb_picker import cmd_arb_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            ent_v,
  input  logic [DEPTH-1:0][AGE_W-1:0] ent_age,
  input  logic [DEPTH-1:0]            ent_hit,
  input  logic [DEPTH-1:0]            ent_wr,
  input  logic [DEPTH-1:0]            ent_hp,
  input  logic [AGE_W-1:0]            starve_limit,
  input  logic                        major_mode,
  input  logic                        last_wr,
  output logic                        sel_any,
  output logic [IDX_W-1:0]            sel_idx
);
  logic [DEPTH-1:0]            starved;
  logic [NTIER-1:0][DEPTH-1:0] mask;
  logic [DEPTH-1:0]            cand;
  logic [AGE_W-1:0]            best_age;
  logic                        found;

  for (genvar i = 0; i < DEPTH; i++) begin : g_starve
    assign starved[i] = ent_age[i] >= starve_limit;
  end

  always_comb begin
    mask[T_STARVED] = ent_v & starved;
    mask[T_HP_HIT]  = ent_v & ent_hp & ent_hit;
    mask[T_HP]      = ent_v & ent_hp;
    mask[T_DIR_HIT] = major_mode ? (ent_v & ent_hit & ~(ent_wr ^ {DEPTH{last_wr}})) : '0;
    mask[T_HIT]     = ent_v & ent_hit;
    mask[T_ANY]     = ent_v;
  end

  always_comb begin
    cand = mask[T_ANY];
    for (int t = NTIER - 1; t >= 0; t--) begin
      if (|mask[t]) cand = mask[t];
    end
    found    = 1'b0;
    best_age = '0;
    sel_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!found || ent_age[i] > best_age)) begin
        found    = 1'b1;
        best_age = ent_age[i];
        sel_idx  = IDX_W'(i);
      end
    end
  end

  assign sel_any = |ent_v;
endmodule

// File: rtl/cmd_arb.sv
module cmd_arb import cmd_arb_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic              in_wr,
  input  logic              in_hipri,
  input  logic [AGE_W-1:0]  starve_limit,
  input  logic              major_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RANK_W-1:0] out_rank,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic              out_wr,
  output logic              out_hipri,
  output logic              out_hit
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]             q_v;
  logic [DEPTH-1:0][AGE_W-1:0]  q_age;
  logic [DEPTH-1:0][RANK_W-1:0] q_rank;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  q_row;
  logic [DEPTH-1:0]             q_wr;
  logic [DEPTH-1:0]             q_hp;
  logic [DEPTH-1:0]             q_hit;
  logic                         last_wr;
  logic [IDX_W-1:0]             free_idx;
  logic [IDX_W-1:0]             sel_idx;
  logic                         sel_any;
  logic                         acc;
  logic                         gnt;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!q_v[i]) free_idx = IDX_W'(i);
    end
  end

  assign in_ready = ~(&q_v);
  assign acc      = in_valid && in_ready;
  assign gnt      = out_valid && out_ready;

  cmd_arb_open_rows #(
    .DEPTH(DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) i_open_rows (
    .clk(clk), .rst_n(rst_n), .upd(gnt),
    .upd_rank(out_rank), .upd_bank(out_bank), .upd_row(out_row),
    .ent_rank(q_rank), .ent_bank(q_bank), .ent_row(q_row),
    .ent_hit(q_hit)
  );

  cmd_arb_picker #(.DEPTH(DEPTH)) i_picker (
    .ent_v(q_v), .ent_age(q_age), .ent_hit(q_hit), .ent_wr(q_wr), .ent_hp(q_hp),
    .starve_limit(starve_limit), .major_mode(major_mode), .last_wr(last_wr),
    .sel_any(sel_any), .sel_idx(sel_idx)
  );

  assign out_valid = sel_any;
  assign out_rank  = q_rank[sel_idx];
  assign out_bank  = q_bank[sel_idx];
  assign out_row   = q_row[sel_idx];
  assign out_wr    = q_wr[sel_idx];
  assign out_hipri = q_hp[sel_idx];
  assign out_hit   = q_hit[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v     <= '0;
      q_age   <= '0;
      q_rank  <= '0;
      q_bank  <= '0;
      q_row   <= '0;
      q_wr    <= '0;
      q_hp    <= '0;
      last_wr <= 1'b0;
    end else begin
      if (gnt) last_wr <= q_wr[sel_idx];
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt && (sel_idx == IDX_W'(i))) begin
          q_v[i] <= 1'b0;
        end else if (acc && (free_idx == IDX_W'(i))) begin
          q_v[i]    <= 1'b1;
          q_age[i]  <= '0;
          q_rank[i] <= in_rank;
          q_bank[i] <= in_bank;
          q_row[i]  <= in_row;
          q_wr[i]   <= in_wr;
          q_hp[i]   <= in_hipri;
        end else if (gnt && q_v[i] && (q_age[i] != AGE_W'(AGE_MAX))) begin
          q_age[i] <= q_age[i] + 1'b1;
        end
      end
    end
  end

  // Checking views of the pool, separate from the picker's own masks
  logic [DEPTH-1:0] chk_starved;
  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    assign chk_starved[i] = q_v[i] && (q_age[i] >= starve_limit);
  end

  // R1: occupancy follows accepts and grants
  a_r1_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(q_v) == $countones($past(q_v))
                       + ($past(acc) ? 1 : 0) - ($past(gnt) ? 1 : 0)));

  // R2: an offered command is not withdrawn without a grant
  a_r2_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R4: a starved request exists, so the grant goes to one
  a_r4_starved_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && (|chk_starved)) |-> (q_age[sel_idx] >= starve_limit));

  // R5: no starved request and an urgent one held, so the grant is urgent
  a_r5_hipri_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !(|chk_starved) && (|(q_v & q_hp))) |-> out_hipri);
endmodule

// File: tb/test_cmd_arb.sv
module test_cmd_arb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NKEY  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic [0:0] in_rank;
  logic [1:0] in_bank;
  logic [3:0] in_row;
  logic       in_wr, in_hipri;
  logic [5:0] starve_limit;
  logic       major_mode;
  logic       out_valid, out_ready;
  logic [0:0] out_rank;
  logic [1:0] out_bank;
  logic [3:0] out_row;
  logic       out_wr, out_hipri, out_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_arb i_cmd_arb (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_rank(in_rank), .in_bank(in_bank), .in_row(in_row),
    .in_wr(in_wr), .in_hipri(in_hipri),
    .starve_limit(starve_limit), .major_mode(major_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_rank(out_rank), .out_bank(out_bank), .out_row(out_row),
    .out_wr(out_wr), .out_hipri(out_hipri), .out_hit(out_hit)
  );

  // Reference pool built from the requirements
  bit m_v[DEPTH];
  int m_age[DEPTH], m_rank[DEPTH], m_bank[DEPTH], m_row[DEPTH];
  bit m_wr[DEPTH], m_hp[DEPTH];
  bit m_ov[NKEY];
  int m_orow[NKEY];
  bit m_last_wr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_hit(int i);
    int k = m_rank[i] * 4 + m_bank[i];
    return m_ov[k] && (m_orow[k] == m_row[i]);
  endfunction

  function automatic bit in_tier(int t, int i);
    if (!m_v[i]) return 0;
    case (t)
      0: return m_age[i] >= int'(starve_limit);
      1: return m_hp[i] && m_hit(i);
      2: return m_hp[i];
      3: return major_mode && m_hit(i) && (m_wr[i] == m_last_wr);
      4: return m_hit(i);
      default: return 1;
    endcase
  endfunction

  // Returns slot, or -1 when empty; tier reported through tier
  function automatic int m_pick(output int tier);
    tier = 5;
    for (int t = 0; t < 6; t++) begin
      int best = -1;
      for (int i = 0; i < DEPTH; i++)
        if (in_tier(t, i) && (best < 0 || m_age[i] > m_age[best])) best = i;
      if (best >= 0) begin
        tier = t;
        return best;
      end
    end
    return -1;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += m_v[i];
    return c;
  endfunction

  task automatic check_outputs();
    int tier;
    int s = m_pick(tier);
    string tag;
    check(in_ready == (m_count() < DEPTH), "R1 in_ready", in_ready, m_count() < DEPTH);
    check(out_valid == (s >= 0), "R2 out_valid", out_valid, s >= 0);
    if (s >= 0) begin
      case (tier)
        0: tag = "R4 starved (R3 ages)";
        1: tag = "R5 urgent hit";
        2: tag = "R5 urgent";
        3: tag = "R7 same-direction hit";
        4: tag = "R6 row hit";
        default: tag = "R8 oldest";
      endcase
      check({out_rank, out_bank, out_row, out_wr, out_hipri} ==
            {1'(m_rank[s]), 2'(m_bank[s]), 4'(m_row[s]), m_wr[s], m_hp[s]},
            tag, {out_rank, out_bank, out_row, out_wr, out_hipri},
            {1'(m_rank[s]), 2'(m_bank[s]), 4'(m_row[s]), m_wr[s], m_hp[s]});
      check(out_hit == m_hit(s), "R6 out_hit", out_hit, m_hit(s));
    end
  endtask

  task automatic model_step();
    int tier;
    int s = m_pick(tier);
    bit g = (s >= 0) && out_ready;
    bit a = in_valid && (m_count() < DEPTH);
    int f = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) f = i;
    if (g) begin
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i] && i != s && m_age[i] < 63) m_age[i]++;
      m_v[s] = 0;
      m_ov[m_rank[s] * 4 + m_bank[s]] = 1;
      m_orow[m_rank[s] * 4 + m_bank[s]] = m_row[s];
      m_last_wr = m_wr[s];
    end
    if (a) begin
      m_v[f] = 1; m_age[f] = 0;
      m_rank[f] = in_rank; m_bank[f] = in_bank; m_row[f] = in_row;
      m_wr[f] = in_wr; m_hp[f] = in_hipri;
    end
  endtask

  initial begin
    int limits[5] = '{0, 1, 3, 20, 63};
    rst_n = 1'b0; in_valid = 0; in_rank = 0; in_bank = 0; in_row = 0;
    in_wr = 0; in_hipri = 0; starve_limit = 6'd8; major_mode = 0; out_ready = 0;
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_age[i] = 0; end
    for (int k = 0; k < NKEY; k++) begin m_ov[k] = 0; m_orow[k] = 0; end
    m_last_wr = 0;
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 5; p++) begin
      for (int mm = 0; mm < 2; mm++) begin
        starve_limit = 6'(limits[p]);
        major_mode = mm[0];
        for (int c = 0; c < 600; c++) begin
          if (c > 0 || p > 0 || mm > 0) check_outputs();
          in_valid  = ($urandom % 4) != 0;
          in_rank   = 1'($urandom % 2);
          in_bank   = 2'($urandom % 2);
          in_row    = 4'($urandom % 3);
          in_wr     = ($urandom % 3) == 0;
          in_hipri  = ($urandom % 6) == 0;
          out_ready = (c % 150 < 40) ? (($urandom % 4) == 0) : (($urandom % 3) != 0);
          model_step();
          @(negedge clk);
        end
      end
    end
    check_outputs();
    out_ready = 1; in_valid = 0;
    for (int c = 0; c < 12; c++) begin
      model_step();
      @(negedge clk);
      check_outputs();
    end
    check(out_valid == 1'b0, "R2 drained", out_valid, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule